// File: doc/BRIEF.md
# Shuffle-State Pseudo-Random Number Core

This core produces blocks of pseudo-random 32-bit words. It keeps a 32-word state table and a 32-word result table, plus two 32-bit accumulators. Software first fills the state table through a seed port, one word per strobe. A single `gen` pulse then starts a run of a fixed number of update iterations. Every iteration reads the state table several times, writes one new state word and writes one result word.

Each iteration is split into two four-cycle pipeline stages, and the two stages overlap. The stage that fetches operands for iteration i+1 runs while the stage that finishes iteration i computes its results. The state table has two read ports and one write port. Two read-after-write hazards arise inside the loop, and address comparison with forwarding resolves both. The result is the same as running the loop one iteration at a time. When the run completes, `done` pulses. Read strobes then return the result words one at a time, in order.

Top module: `prng_shuffle_core`

## Requirements
- R1: Reset sets `done`, `rdy` and `rnd_out` to 0 and clears both accumulators, the iteration counter, the seed pointer and the read pointer. With an all-zero seed after reset, a run yields 32 zero result words.
- R2: The k-th accepted seed strobe since reset writes `seed_in` into state word k mod 32. A strobe is accepted only while no run is active and `gen` is low. Strobes during a run change neither the table nor the pointer.
- R3: Iteration i uses word index i mod 32 and computes the following, with all sums modulo 2^32. First X = S[i], then A = ((A<<19) ^ (A>>13)) + S[(i+16) mod 32]. Next Y = S[X mod 32] + A + B, which is written to S[i]. Finally B = S[(Y>>8) mod 32] + X, which is written to Res[i].
- R4: One run performs 256 iterations, i = 0..255. The accumulators and the state table carry over from one run to the next.
- R5: The results equal the one-at-a-time loop in two cases. One is when X mod 32 equals the index written by the previous iteration. The other is when (Y>>8) mod 32 equals the current index.
- R6: `done` is high for exactly one cycle. It rises on the 1028th rising clock edge after the edge that sampled `gen` high on an idle core.
- R7: A `gen` pulse during an active run is ignored and does not shift the time at which `done` rises.
- R8: The read pointer is cleared when a run starts. A read strobe on an idle core with `gen` low makes `rdy` high for one cycle and puts Res[pointer] on `rnd_out` in the next cycle, after which the pointer advances and wraps from 31 to 0. `rdy` is never high without a strobe in the cycle before.
- R9: A read strobe during a run is ignored: `rdy` stays low and the read pointer does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_in | input | 32 | Seed word to write into the state table |
| seed_load | input | 1 | Seed strobe, one word per cycle |
| gen | input | 1 | Start-run pulse |
| read_req | input | 1 | Read strobe for the next result word |
| rnd_out | output | 32 | Result word returned by the last read |
| rdy | output | 1 | Result word valid, one cycle |
| done | output | 1 | Run-complete pulse |

## Verification
The first pattern is an all-zero seed right after reset. It is a fixed point, so any leftover accumulator value or a stray forwarded word shows up as a nonzero result. A counting seed and a pseudo-random seed spread the indirect indices across the table, so both forwarding compares fire many times in a run, and a wrong forward or a missing forward changes every later word. A constant small seed points every early X at the same word, which concentrates the stage-one hazard. A second run without reseeding tells apart a core that really carries its state over from one that restarts from its seed.

// File: rtl/prng_shuffle_pkg.sv
package prng_shuffle_pkg;

   // Four phases per stage window; both stages share the phase counter.
   typedef enum logic [1:0] {
      PH_FETCH_HI = 2'd0,
      PH_FETCH_X  = 2'd1,
      PH_INDIRECT = 2'd2,
      PH_COMBINE  = 2'd3
   } phase_e;

   localparam int STATE_RD_PORTS = 2;
   localparam int PORT_S1        = 0;
   localparam int PORT_S2        = 1;
   localparam int PHASES         = 4;

endpackage

// File: rtl/prng_regfile.sv
module prng_regfile #(
   parameter int W   = 32,
   parameter int AW  = 5,
   parameter int NRD = 2
) (
   input  logic                   clk,
   input  logic                   we,
   input  logic [AW-1:0]          waddr,
   input  logic [W-1:0]           wdata,
   input  logic [NRD-1:0][AW-1:0] raddr,
   output logic [NRD-1:0][W-1:0]  rdata
);
   localparam int DEPTH = 1 << AW;

   if (NRD < 1) begin : g_bad_ports
      $error("prng_regfile: at least one read port is required");
   end
   if (AW < 1) begin : g_bad_aw
      $error("prng_regfile: address width must be positive");
   end

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = mem[raddr[p]];
   end
endmodule

// File: rtl/prng_seq.sv
module prng_seq
   import prng_shuffle_pkg::*;
#(
   parameter int ITERS  = 256,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              gen,
   output phase_e            ph,
   output logic              s1_v,
   output logic              s2_v,
   output logic              busy,
   output logic              start,
   output logic              done,
   output logic [ADDR_W-1:0] idx1,
   output logic [ADDR_W-1:0] idx2
);
   localparam int            IW   = $clog2(ITERS);
   localparam logic [IW-1:0] LAST = IW'(ITERS - 1);

   logic [IW-1:0] cnt1, cnt2;

   assign busy  = s1_v | s2_v;
   assign start = gen & ~busy;
   assign idx1  = cnt1[ADDR_W-1:0];
   assign idx2  = cnt2[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         ph   <= PH_FETCH_HI;
         s1_v <= 1'b0;
         s2_v <= 1'b0;
         cnt1 <= '0;
         cnt2 <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            ph <= PH_FETCH_HI;
            if (gen) begin
               s1_v <= 1'b1;
               cnt1 <= '0;
            end
         end else begin
            ph <= phase_e'(ph + 2'd1);
            if (ph == PH_COMBINE) begin
               // hand the finished stage-one iteration to stage two
               s2_v <= s1_v;
               cnt2 <= cnt1;
               if (s1_v) begin
                  if (cnt1 == LAST) s1_v <= 1'b0;
                  else              cnt1 <= cnt1 + IW'(1);
               end
               if (s2_v && cnt2 == LAST) done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/prng_shuffle_core.sv
module prng_shuffle_core
   import prng_shuffle_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5,
   parameter int ITERS   = 256,
   parameter int ROT_L   = 19,
   parameter int ROT_R   = 13,
   parameter int Y_SHIFT = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] seed_in,
   input  logic              seed_load,
   input  logic              gen,
   input  logic              read_req,
   output logic [DATA_W-1:0] rnd_out,
   output logic              rdy,
   output logic              done
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int HALF  = DEPTH / 2;

   if (Y_SHIFT + ADDR_W > DATA_W) begin : g_bad_shift
      $error("prng_shuffle_core: indirect index field exceeds the word");
   end
   if (ITERS < DEPTH) begin : g_bad_iters
      $error("prng_shuffle_core: a run must cover the whole table");
   end
   if (ROT_L >= DATA_W || ROT_R >= DATA_W) begin : g_bad_rot
      $error("prng_shuffle_core: mixing shifts must be below the word width");
   end

   function automatic logic [DATA_W-1:0] scramble(input logic [DATA_W-1:0] v);
      return (v << ROT_L) ^ (v >> ROT_R);
   endfunction

   // sequencing
   phase_e            ph;
   logic              s1_v, s2_v, busy, start;
   logic [ADDR_W-1:0] idx1, idx2;

   prng_seq #(.ITERS(ITERS), .ADDR_W(ADDR_W)) u_seq (
      .clk  (clk),
      .rst  (rst),
      .gen  (gen),
      .ph   (ph),
      .s1_v (s1_v),
      .s2_v (s2_v),
      .busy (busy),
      .start(start),
      .done (done),
      .idx1 (idx1),
      .idx2 (idx2)
   );

   // datapath registers
   logic [DATA_W-1:0] acc_a, acc_b;
   logic [DATA_W-1:0] hi_word, x1, ind_word;
   logic [DATA_W-1:0] x2, y1_2, y_val, far_word;
   logic              fwd1, fwd2;

   // port-side control
   logic [ADDR_W-1:0] seed_ptr, rd_ptr;
   logic              seed_take, read_take;

   assign seed_take = seed_load & ~busy & ~gen;
   assign read_take = read_req & ~busy & ~gen;

   // state table: stage one on port 0, stage two on port 1
   logic [STATE_RD_PORTS-1:0][ADDR_W-1:0] m_raddr;
   logic [STATE_RD_PORTS-1:0][DATA_W-1:0] m_rdata;
   logic                                  m_we;
   logic [ADDR_W-1:0]                     m_waddr;
   logic [DATA_W-1:0]                     m_wdata;

   always_comb begin
      unique case (ph)
         PH_FETCH_HI: m_raddr[PORT_S1] = idx1 + ADDR_W'(HALF);
         PH_FETCH_X:  m_raddr[PORT_S1] = idx1;
         default:     m_raddr[PORT_S1] = x1[ADDR_W-1:0];
      endcase
      m_raddr[PORT_S2] = y_val[Y_SHIFT +: ADDR_W];
   end

   assign m_we    = (s2_v && ph == PH_COMBINE) || seed_take;
   assign m_waddr = s2_v ? idx2 : seed_ptr;
   assign m_wdata = s2_v ? y_val : seed_in;

   prng_regfile #(.W(DATA_W), .AW(ADDR_W), .NRD(STATE_RD_PORTS)) u_state (
      .clk  (clk),
      .we   (m_we),
      .waddr(m_waddr),
      .wdata(m_wdata),
      .raddr(m_raddr),
      .rdata(m_rdata)
   );

   // result table: one read port for the output side
   logic [0:0][ADDR_W-1:0] r_raddr;
   logic [0:0][DATA_W-1:0] r_rdata;
   logic                   r_we;

   assign r_raddr[0] = rd_ptr;
   assign r_we       = s2_v && ph == PH_COMBINE;

   prng_regfile #(.W(DATA_W), .AW(ADDR_W), .NRD(1)) u_result (
      .clk  (clk),
      .we   (r_we),
      .waddr(idx2),
      .wdata(acc_b),
      .raddr(r_raddr),
      .rdata(r_rdata)
   );

   // two-stage update
   always_ff @(posedge clk) begin
      if (rst) begin
         acc_a    <= '0;
         acc_b    <= '0;
         hi_word  <= '0;
         x1       <= '0;
         ind_word <= '0;
         x2       <= '0;
         y1_2     <= '0;
         y_val    <= '0;
         far_word <= '0;
         fwd1     <= 1'b0;
         fwd2     <= 1'b0;
      end else begin
         if (s1_v) begin
            unique case (ph)
               PH_FETCH_HI: hi_word <= m_rdata[PORT_S1];
               PH_FETCH_X: begin
                  x1    <= m_rdata[PORT_S1];
                  acc_a <= scramble(acc_a) + hi_word;
               end
               PH_INDIRECT: begin
                  ind_word <= m_rdata[PORT_S1];
                  // the previous iteration writes its index only at the end of this window
                  fwd1     <= s2_v && (x1[ADDR_W-1:0] == idx2);
               end
               PH_COMBINE: begin
                  y1_2 <= acc_a + (fwd1 ? y_val : ind_word);
                  x2   <= x1;
               end
            endcase
         end
         if (s2_v) begin
            unique case (ph)
               PH_FETCH_HI: y_val <= acc_b + y1_2;
               PH_FETCH_X: begin
                  far_word <= m_rdata[PORT_S2];
                  fwd2     <= (y_val[Y_SHIFT +: ADDR_W] == idx2);
               end
               PH_INDIRECT: acc_b <= x2 + (fwd2 ? y_val : far_word);
               default: ;
            endcase
         end
      end
   end

   // seed and read side
   always_ff @(posedge clk) begin
      if (rst) begin
         seed_ptr <= '0;
         rd_ptr   <= '0;
         rdy      <= 1'b0;
         rnd_out  <= '0;
      end else begin
         if (seed_take) seed_ptr <= seed_ptr + ADDR_W'(1);
         rdy <= read_take;
         if (start) begin
            rd_ptr <= '0;
         end else if (read_take) begin
            rd_ptr  <= rd_ptr + ADDR_W'(1);
            rnd_out <= r_rdata[0];
         end
      end
   end
endmodule

// File: rtl/prng_shuffle_chk.sv
module prng_shuffle_chk #(
   parameter int ITERS  = 256,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              gen,
   input logic              seed_load,
   input logic              read_req,
   input logic              busy,
   input logic              done,
   input logic              rdy,
   input logic [ADDR_W-1:0] seed_ptr,
   input logic [ADDR_W-1:0] rd_ptr
);
   localparam int RUN_CYC = (ITERS + 1) * 4;
   localparam int CW      = $clog2(RUN_CYC + 1) + 1;

   logic [CW-1:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (rst)       busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + CW'(1);
      else           busy_cnt <= '0;
   end

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   p_done_latency_r6: assert property (@(posedge clk) disable iff (rst)
      done |-> busy_cnt == CW'(RUN_CYC));

   p_run_ends_r4: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> done);

   p_run_start_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(gen));

   p_seed_ignored_r2: assert property (@(posedge clk) disable iff (rst)
      (busy && seed_load) |=> $stable(seed_ptr));

   p_read_served_r8: assert property (@(posedge clk) disable iff (rst)
      (!busy && !gen && read_req) |=> rdy);

   p_rdy_cause_r8: assert property (@(posedge clk) disable iff (rst)
      rdy |-> $past(read_req));

   p_read_ignored_r9: assert property (@(posedge clk) disable iff (rst)
      (busy && read_req) |=> (!rdy && $stable(rd_ptr)));
endmodule

bind prng_shuffle_core prng_shuffle_chk #(.ITERS(ITERS), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .gen      (gen),
   .seed_load(seed_load),
   .read_req (read_req),
   .busy     (busy),
   .done     (done),
   .rdy      (rdy),
   .seed_ptr (seed_ptr),
   .rd_ptr   (rd_ptr)
);

// File: tb/test_prng_shuffle_core.sv
`timescale 1ns/1ps
module test_prng_shuffle_core;
   localparam int ITERS     = 256;
   localparam int RUN_EDGES = (ITERS + 1) * 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] seed_in = '0;
   logic        seed_load = 1'b0;
   logic        gen = 1'b0;
   logic        read_req = 1'b0;
   logic [31:0] rnd_out;
   logic        rdy, done;

   prng_shuffle_core i_prng_shuffle_core (
      .clk      (clk),
      .rst      (rst),
      .seed_in  (seed_in),
      .seed_load(seed_load),
      .gen      (gen),
      .read_req (read_req),
      .rnd_out  (rnd_out),
      .rdy      (rdy),
      .done     (done)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   // behavioural model of the loop
   logic [31:0] mm [32];
   logic [31:0] rr [32];
   logic [31:0] ma, mb;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_run();
      for (int i = 0; i < ITERS; i++) begin
         logic [31:0] x, y;
         x  = mm[i & 31];
         ma = ((ma << 19) ^ (ma >> 13)) + mm[(i + 16) & 31];
         y  = mm[x[4:0]] + ma + mb;
         mm[i & 31] = y;
         mb = mm[y[12:8]] + x;
         rr[i & 31] = mb;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1; seed_load = 1'b0; gen = 1'b0; read_req = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      ma = '0;
      mb = '0;
      @(posedge clk);
      @(negedge clk);
      check(done == 1'b0, "R1 done after reset", 32'(done), 32'h0);
      check(rdy == 1'b0, "R1 rdy after reset", 32'(rdy), 32'h0);
      check(rnd_out == 32'h0, "R1 rnd_out after reset", rnd_out, 32'h0);
   endtask

   // kind: 0 zero, 1 counting, 2 pseudo-random, 3 constant
   task automatic t_load(input int kind);
      logic [31:0] lcg;
      lcg = 32'h1234_5678;
      for (int k = 0; k < 32; k++) begin
         logic [31:0] w;
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         case (kind)
            0:       w = 32'h0;
            1:       w = 32'(k) * 32'h0101_0101 + 32'h0002_0406;
            2:       w = lcg;
            default: w = 32'h0000_0007;
         endcase
         @(negedge clk);
         seed_in   = w;
         seed_load = 1'b1;
         mm[k]     = w;
      end
      @(negedge clk);
      seed_load = 1'b0;
   endtask

   task automatic t_run(input bit disturb);
      int  cnt;
      bit  seen;
      cnt  = 0;
      seen = 1'b0;
      @(negedge clk);
      gen = 1'b1;
      @(posedge clk);
      @(negedge clk);
      gen = 1'b0;
      while (cnt < 3000 && !seen) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         if (done) begin
            seen = 1'b1;
         end else if (disturb) begin
            if (cnt == 100) read_req = 1'b1;
            if (cnt == 101) begin
               read_req = 1'b0;
               check(rdy == 1'b0, "R9 read during run", 32'(rdy), 32'h0);
            end
            if (cnt == 200) gen = 1'b1;
            if (cnt == 201) gen = 1'b0;
            if (cnt == 300) begin
               seed_in   = 32'hFFFF_FFFF;
               seed_load = 1'b1;
            end
            if (cnt == 304) seed_load = 1'b0;
         end
      end
      check(cnt == RUN_EDGES, disturb ? "R7 done latency with gen mid-run" : "R6 done latency",
            32'(cnt), 32'(RUN_EDGES));
      @(posedge clk);
      @(negedge clk);
      check(done == 1'b0, "R6 done one cycle", 32'(done), 32'h0);
      model_run();
   endtask

   task automatic t_read(input string tag);
      for (int k = 0; k < 32; k++) begin
         @(negedge clk);
         read_req = 1'b1;
         @(posedge clk);
         @(negedge clk);
         read_req = 1'b0;
         check(rdy && rnd_out == rr[k], tag, rnd_out, rr[k]);
      end
      @(posedge clk);
      @(negedge clk);
      check(rdy == 1'b0, "R8 rdy one cycle", 32'(rdy), 32'h0);
   endtask

   task automatic t_wrap();
      @(negedge clk);
      read_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      read_req = 1'b0;
      check(rdy && rnd_out == rr[0], "R8 read pointer wrap", rnd_out, rr[0]);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      t_reset();
      t_load(1);
      t_run(1'b0);
      t_read("R3 counting seed result");
      t_wrap();
      t_run(1'b1);
      t_read("R4 carried-over run result");
      t_load(2);
      t_run(1'b0);
      t_read("R2 reseeded after ignored strobes");
      t_load(3);
      t_run(1'b0);
      t_read("R5 constant seed forwarding result");
      t_reset();
      t_load(0);
      t_run(1'b0);
      t_read("R1 zero seed after reset");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule